// File: doc/BRIEF.md
# Committable Protection and Debug-Lock Register

This block keeps per-region access policy for an on-chip program store: a read-enable bit and a program-enable bit for every region, plus a two-bit debug-enable field. Software writes a working copy of these bits, and that copy drives the access checker at once. The working copy stays provisional. A commit, guarded by a key value, folds it into a modelled non-volatile image that keeps its value through power-on reset. Each power-on reset reloads the working copy from that image, which undoes any change that was never committed.

The image behaves like one-time-programmable storage. A commit can clear image bits but can never set them, so a region that has been locked, or a debug field that has been cleared, stays that way for good. The debug-access output is taken from the committed field only while power-on reset is held, so a change to the field shows up only at the next power-up. The boundary-scan enable output stays asserted in every state.

Top module: `prot_commit_reg`

## Requirements
- R1: After factory initialisation (`fab_init_n` low) and then power-on reset, every bit of `rd_en_o` and `pg_en_o` is 1, `dbg_access_o` is 1 and `commit_busy_o` is 0.
- R2: A write (`wr_en_i` high while `por_n` is high) sets `rd_en_o` and `pg_en_o` to the written values on the next clock edge.
- R3: A working bit that was cleared and never committed goes back to its committed value after a power-on reset.
- R4: A commit request that carries the correct key while idle raises `commit_busy_o` from the next edge, and busy stays high for exactly COMMIT_CYCLES cycles (4 by default).
- R5: A commit request with a wrong key is ignored: busy stays low and the image is unchanged, which the next power-on reset makes visible.
- R6: A commit can only clear image bits. Committing a working 1 over an image 0 leaves a 0 that reappears after the next power-on reset.
- R7: `dbg_access_o` is 1 exactly when the committed debug field equals 2'b10 at power-on reset. Writes and commits to the field have no effect on it until the next power-on reset.
- R8: Once a cleared debug field (2'b00) is committed, later writes and commits of 2'b10 leave `dbg_access_o` at 0 after every later power-on reset.
- R9: `scan_en_o` is 1 at all times, including after debug access has been disabled.
- R10: A correctly keyed commit request that arrives while busy is ignored, and the busy window does not get longer.
- R11: Power-on reset ends a running commit. `commit_busy_o` is 0 after the first edge at which `por_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| fab_init_n | input | 1 | Active-low factory initialisation; sets the image to blank (all ones, debug field 2'b10) |
| por_n | input | 1 | Active-low power-on reset; reloads the working copy and samples debug access |
| wr_en_i | input | 1 | Write strobe for the working copy |
| wr_rd_en_i | input | NUM_REGIONS | Read-enable bits to write |
| wr_pg_en_i | input | NUM_REGIONS | Program-enable bits to write |
| wr_dbg_i | input | 2 | Debug field to write |
| commit_req_i | input | 1 | Commit request strobe |
| commit_key_i | input | KEY_W | Key presented with the commit request |
| commit_busy_o | output | 1 | High while a commit is in progress |
| rd_en_o | output | NUM_REGIONS | Current read-enable bits to the access checker |
| pg_en_o | output | NUM_REGIONS | Current program-enable bits to the access checker |
| dbg_access_o | output | 1 | Debug port access allowed, fixed at power-up |
| scan_en_o | output | 1 | Boundary-scan access enable, always high |

## Verification
Writes show on the region outputs after a single edge. Busy rises one edge after an accepted commit and falls COMMIT_CYCLES edges after that. Committed image contents and the debug-access output appear only after a power-on reset has been asserted for at least one edge and then released. The driver tags every expected item with the rising-edge count at which its result is due, and the monitor compares it at the falling edge that follows that edge. An item whose edge has already passed counts as a mismatch.

// File: rtl/prot_pkg.sv
package prot_pkg;
   localparam int unsigned DBG_W = 2;
   typedef logic [DBG_W-1:0] dbg_field_t;
   localparam dbg_field_t DBG_OPEN  = 2'b10;
   localparam dbg_field_t DBG_BLANK = 2'b10;
endpackage

// File: rtl/prot_commit_ctl.sv
module prot_commit_ctl #(
   parameter int unsigned KEY_W  = 16,
   parameter logic [KEY_W-1:0] KEY = 16'hA442,
   parameter int unsigned CYCLES = 4
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             req_i,
   input  logic [KEY_W-1:0] key_i,
   output logic             accept_o,
   output logic             busy_o
);
   localparam int unsigned CNT_W = $clog2(CYCLES + 1);

   generate
      if (CYCLES < 1) begin : g_bad_cycles
         $error("prot_commit_ctl: CYCLES must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   assign busy_o   = (cnt_q != '0);
   assign accept_o = por_n && req_i && (key_i == KEY) && !busy_o;

   always_ff @(posedge clk) begin
      if (!por_n)        cnt_q <= '0;
      else if (accept_o) cnt_q <= CNT_W'(CYCLES);
      else if (busy_o)   cnt_q <= cnt_q - 1'b1;
   end

   // R4
   busy_start_chk: assert property (@(posedge clk) disable iff (!por_n)
      accept_o |=> busy_o);

   // R5
   busy_needs_key_chk: assert property (@(posedge clk) disable iff (!por_n)
      $rose(busy_o) |-> $past(req_i && (key_i == KEY)));
endmodule

// File: rtl/prot_nv_image.sv
module prot_nv_image #(
   parameter int unsigned NUM_REGIONS = 8
) (
   input  logic                      clk,
   input  logic                      fab_init_n,
   input  logic                      commit_i,
   input  logic [NUM_REGIONS-1:0]    wk_rd_i,
   input  logic [NUM_REGIONS-1:0]    wk_pg_i,
   input  prot_pkg::dbg_field_t      wk_dbg_i,
   output logic [NUM_REGIONS-1:0]    img_rd_o,
   output logic [NUM_REGIONS-1:0]    img_pg_o,
   output prot_pkg::dbg_field_t      img_dbg_o
);
   generate
      for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_cell
         logic rd_q, pg_q;
         always_ff @(posedge clk) begin
            if (!fab_init_n) begin
               rd_q <= 1'b1;
               pg_q <= 1'b1;
            end else if (commit_i) begin
               rd_q <= rd_q & wk_rd_i[i];
               pg_q <= pg_q & wk_pg_i[i];
            end
         end
         assign img_rd_o[i] = rd_q;
         assign img_pg_o[i] = pg_q;
      end
   endgenerate

   prot_pkg::dbg_field_t dbg_q;
   always_ff @(posedge clk) begin
      if (!fab_init_n)   dbg_q <= prot_pkg::DBG_BLANK;
      else if (commit_i) dbg_q <= dbg_q & wk_dbg_i;
   end
   assign img_dbg_o = dbg_q;

   // R6
   otp_clear_only_chk: assert property (@(posedge clk) disable iff (!fab_init_n)
      ((img_rd_o & ~$past(img_rd_o)) == '0) && ((img_pg_o & ~$past(img_pg_o)) == '0));

   // R8
   dbg_lock_chk: assert property (@(posedge clk) disable iff (!fab_init_n)
      (img_dbg_o == '0) |=> (img_dbg_o == '0));
endmodule

// File: rtl/prot_shadow.sv
module prot_shadow #(
   parameter int unsigned NUM_REGIONS = 8
) (
   input  logic                      clk,
   input  logic                      por_n,
   input  logic                      wr_en_i,
   input  logic [NUM_REGIONS-1:0]    wr_rd_i,
   input  logic [NUM_REGIONS-1:0]    wr_pg_i,
   input  prot_pkg::dbg_field_t      wr_dbg_i,
   input  logic [NUM_REGIONS-1:0]    img_rd_i,
   input  logic [NUM_REGIONS-1:0]    img_pg_i,
   input  prot_pkg::dbg_field_t      img_dbg_i,
   output logic [NUM_REGIONS-1:0]    rd_o,
   output logic [NUM_REGIONS-1:0]    pg_o,
   output prot_pkg::dbg_field_t      wk_dbg_o,
   output logic                      dbg_access_o
);
   logic [NUM_REGIONS-1:0] rd_q, pg_q;
   prot_pkg::dbg_field_t   dbg_q;
   logic                   acc_q, por_d_q;

   always_ff @(posedge clk) begin
      if (!por_n) begin
         rd_q  <= img_rd_i;
         pg_q  <= img_pg_i;
         dbg_q <= img_dbg_i;
      end else if (wr_en_i) begin
         rd_q  <= wr_rd_i;
         pg_q  <= wr_pg_i;
         dbg_q <= wr_dbg_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!por_n) acc_q <= (img_dbg_i == prot_pkg::DBG_OPEN);
   end

   always_ff @(posedge clk) begin
      por_d_q <= por_n;
   end

   assign rd_o         = rd_q;
   assign pg_o         = pg_q;
   assign wk_dbg_o     = dbg_q;
   assign dbg_access_o = acc_q;

   // R2
   wr_update_chk: assert property (@(posedge clk) disable iff (!por_n)
      wr_en_i |=> (rd_o == $past(wr_rd_i)) && (pg_o == $past(wr_pg_i)));

   // R7
   dbg_frozen_chk: assert property (@(posedge clk) disable iff (!por_n)
      por_d_q |-> $stable(dbg_access_o));
endmodule

// File: rtl/prot_commit_reg.sv
module prot_commit_reg #(
   parameter int unsigned NUM_REGIONS   = 8,
   parameter int unsigned KEY_W         = 16,
   parameter logic [KEY_W-1:0] COMMIT_KEY = 16'hA442,
   parameter int unsigned COMMIT_CYCLES = 4
) (
   input  logic                   clk,
   input  logic                   fab_init_n,
   input  logic                   por_n,
   input  logic                   wr_en_i,
   input  logic [NUM_REGIONS-1:0] wr_rd_en_i,
   input  logic [NUM_REGIONS-1:0] wr_pg_en_i,
   input  logic [1:0]             wr_dbg_i,
   input  logic                   commit_req_i,
   input  logic [KEY_W-1:0]       commit_key_i,
   output logic                   commit_busy_o,
   output logic [NUM_REGIONS-1:0] rd_en_o,
   output logic [NUM_REGIONS-1:0] pg_en_o,
   output logic                   dbg_access_o,
   output logic                   scan_en_o
);
   generate
      if (NUM_REGIONS < 1) begin : g_bad_regions
         $error("prot_commit_reg: NUM_REGIONS must be at least 1");
      end
      if (KEY_W < 1) begin : g_bad_key
         $error("prot_commit_reg: KEY_W must be at least 1");
      end
   endgenerate

   logic                   commit_go;
   logic [NUM_REGIONS-1:0] img_rd, img_pg;
   prot_pkg::dbg_field_t   img_dbg, wk_dbg;

   prot_commit_ctl #(
      .KEY_W (KEY_W),
      .KEY   (COMMIT_KEY),
      .CYCLES(COMMIT_CYCLES)
   ) u_ctl (
      .clk     (clk),
      .por_n   (por_n),
      .req_i   (commit_req_i),
      .key_i   (commit_key_i),
      .accept_o(commit_go),
      .busy_o  (commit_busy_o)
   );

   prot_nv_image #(.NUM_REGIONS(NUM_REGIONS)) u_img (
      .clk       (clk),
      .fab_init_n(fab_init_n),
      .commit_i  (commit_go),
      .wk_rd_i   (rd_en_o),
      .wk_pg_i   (pg_en_o),
      .wk_dbg_i  (wk_dbg),
      .img_rd_o  (img_rd),
      .img_pg_o  (img_pg),
      .img_dbg_o (img_dbg)
   );

   prot_shadow #(.NUM_REGIONS(NUM_REGIONS)) u_shadow (
      .clk         (clk),
      .por_n       (por_n),
      .wr_en_i     (wr_en_i),
      .wr_rd_i     (wr_rd_en_i),
      .wr_pg_i     (wr_pg_en_i),
      .wr_dbg_i    (wr_dbg_i),
      .img_rd_i    (img_rd),
      .img_pg_i    (img_pg),
      .img_dbg_i   (img_dbg),
      .rd_o        (rd_en_o),
      .pg_o        (pg_en_o),
      .wk_dbg_o    (wk_dbg),
      .dbg_access_o(dbg_access_o)
   );

   assign scan_en_o = 1'b1;
endmodule

// File: tb/tb_prot_commit_reg.sv
module tb_prot_commit_reg;
   localparam int N = 8;
   localparam logic [15:0] KEY = 16'hA442;

   logic clk = 1'b0;
   logic fab_init_n = 1'b0, por_n = 1'b0, wr_en = 1'b0, req = 1'b0;
   logic [N-1:0] wr_rd = '0, wr_pg = '0;
   logic [1:0] wr_dbg = '0;
   logic [15:0] key = '0;
   logic busy, dbg_acc, scan_en;
   logic [N-1:0] rd_en, pg_en;

   always #4 clk = ~clk;

   prot_commit_reg dut (
      .clk(clk), .fab_init_n(fab_init_n), .por_n(por_n),
      .wr_en_i(wr_en), .wr_rd_en_i(wr_rd), .wr_pg_en_i(wr_pg), .wr_dbg_i(wr_dbg),
      .commit_req_i(req), .commit_key_i(key), .commit_busy_o(busy),
      .rd_en_o(rd_en), .pg_en_o(pg_en), .dbg_access_o(dbg_acc), .scan_en_o(scan_en)
   );

   typedef struct {
      int          cyc;
      string       tag;
      logic [N-1:0] rd, pg;
      logic        dbg, busy;
   } exp_t;

   exp_t q[$];
   int n_pos = 0;
   int compared = 0, mismatched = 0;
   bit done = 0;

   always @(posedge clk) n_pos++;

   always @(negedge clk) begin
      while (q.size() > 0 && q[0].cyc <= n_pos) begin
         exp_t e;
         bit bad;
         e = q.pop_front();
         bad = 0;
         compared++;
         if (e.cyc < n_pos) begin
            $display("FAIL %s stale item: act cycle %0d exp cycle %0d", e.tag, n_pos, e.cyc);
            bad = 1;
         end else begin
            if (rd_en !== e.rd) begin
               $display("FAIL %s rd_en: act %h exp %h", e.tag, rd_en, e.rd); bad = 1;
            end
            if (pg_en !== e.pg) begin
               $display("FAIL %s pg_en: act %h exp %h", e.tag, pg_en, e.pg); bad = 1;
            end
            if (dbg_acc !== e.dbg) begin
               $display("FAIL %s dbg_access: act %b exp %b", e.tag, dbg_acc, e.dbg); bad = 1;
            end
            if (busy !== e.busy) begin
               $display("FAIL %s busy: act %b exp %b", e.tag, busy, e.busy); bad = 1;
            end
            if (scan_en !== 1'b1) begin
               $display("FAIL R9 scan_en: act %b exp 1", scan_en); bad = 1;
            end
         end
         if (bad) mismatched++;
      end
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic expect_now(string tag, logic [N-1:0] rd, logic [N-1:0] pg, logic dbg, logic bsy);
      exp_t e;
      e.cyc = n_pos; e.tag = tag; e.rd = rd; e.pg = pg; e.dbg = dbg; e.busy = bsy;
      q.push_back(e);
   endtask

   task automatic write_wk(logic [N-1:0] rd, logic [N-1:0] pg, logic [1:0] d);
      wr_en = 1'b1; wr_rd = rd; wr_pg = pg; wr_dbg = d;
      tick();
      wr_en = 1'b0;
   endtask

   task automatic commit(logic [15:0] k);
      req = 1'b1; key = k;
      tick();
      req = 1'b0; key = '0;
   endtask

   task automatic por_cycle();
      por_n = 1'b0;
      tick();
      por_n = 1'b1;
      tick();
   endtask

   task automatic wait_idle();
      repeat (4) tick();
   endtask

   initial begin
      #1;
      repeat (3) tick();
      fab_init_n = 1'b1;
      repeat (2) tick();
      por_n = 1'b1;
      tick();
      // R1: blank device, open access
      expect_now("R1", 8'hFF, 8'hFF, 1'b1, 1'b0);

      // R2: write goes straight to the outputs
      write_wk(8'hF0, 8'h0F, 2'b10);
      expect_now("R2", 8'hF0, 8'h0F, 1'b1, 1'b0);

      // R5: wrong key
      commit(16'h1234);
      expect_now("R5", 8'hF0, 8'h0F, 1'b1, 1'b0);
      tick();
      expect_now("R5", 8'hF0, 8'h0F, 1'b1, 1'b0);

      // R3: uncommitted clears undone by power-on reset (also shows R5 left image blank)
      por_cycle();
      expect_now("R3", 8'hFF, 8'hFF, 1'b1, 1'b0);

      // R4 / R10: keyed commit, busy window of four cycles, second request ignored
      write_wk(8'hF0, 8'h3C, 2'b10);
      expect_now("R2", 8'hF0, 8'h3C, 1'b1, 1'b0);
      commit(KEY);
      expect_now("R4", 8'hF0, 8'h3C, 1'b1, 1'b1);
      tick();
      expect_now("R4", 8'hF0, 8'h3C, 1'b1, 1'b1);
      commit(KEY);
      expect_now("R10", 8'hF0, 8'h3C, 1'b1, 1'b1);
      tick();
      expect_now("R4", 8'hF0, 8'h3C, 1'b1, 1'b1);
      tick();
      expect_now("R10", 8'hF0, 8'h3C, 1'b1, 1'b0);

      // R6: committing ones over zeros cannot restore them
      write_wk(8'hFF, 8'hFF, 2'b10);
      expect_now("R6", 8'hFF, 8'hFF, 1'b1, 1'b0);
      commit(KEY);
      wait_idle();
      expect_now("R6", 8'hFF, 8'hFF, 1'b1, 1'b0);
      por_cycle();
      expect_now("R6", 8'hF0, 8'h3C, 1'b1, 1'b0);

      // R7: debug field change without commit, then with commit
      write_wk(8'hF0, 8'h3C, 2'b00);
      expect_now("R7", 8'hF0, 8'h3C, 1'b1, 1'b0);
      por_cycle();
      expect_now("R7", 8'hF0, 8'h3C, 1'b1, 1'b0);
      write_wk(8'hF0, 8'h3C, 2'b00);
      commit(KEY);
      wait_idle();
      expect_now("R7", 8'hF0, 8'h3C, 1'b1, 1'b0);
      por_cycle();
      expect_now("R7", 8'hF0, 8'h3C, 1'b0, 1'b0);

      // R8: restoring the committed debug field has no effect
      write_wk(8'hF0, 8'h3C, 2'b10);
      commit(KEY);
      wait_idle();
      por_cycle();
      expect_now("R8", 8'hF0, 8'h3C, 1'b0, 1'b0);

      // R11: power-on reset ends a running commit
      commit(KEY);
      expect_now("R11", 8'hF0, 8'h3C, 1'b0, 1'b1);
      por_n = 1'b0;
      tick();
      expect_now("R11", 8'hF0, 8'h3C, 1'b0, 1'b0);
      por_n = 1'b1;
      tick();
      expect_now("R9", 8'hF0, 8'h3C, 1'b0, 1'b0);

      tick();
      tick();
      if (q.size() != 0) begin
         $display("FAIL queue: act %0d items left exp 0", q.size());
         mismatched++;
      end
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         mismatched++;
         $display("FAIL watchdog: act timeout exp finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end
endmodule